// File: doc/BRIEF.md
# Single-Master I2C Byte Controller

This block is a reduced I2C master for a bus on which it is the only master, intended for simple peripherals such as serial memories and converters. Software drives the bus one command at a time. There are four commands: generate a start condition, generate a stop condition, write one byte, and read one byte. The block never chains these on its own. It drives SCL as a push-pull output. It drives SDA only as an open-drain pull-down, and it reads the resolved bus level back on a separate input.

Bytes are 8 bits and go MSB first. When a byte is an address, its upper seven bits carry the target address and bit 0 selects the direction (1 read, 0 write). After a write, the block samples the acknowledge bit. A high level there (NACK) sets a sticky error flag. After a read, the block either drives the acknowledge low or leaves SDA released, which gives a NACK on the last byte. The choice comes from an enable captured when the command is accepted.

Every command ends with a one-cycle completion pulse. A command issued while one is still running is dropped and recorded in a sticky overrun flag. There is no arbitration, no clock-stretch detection and no slave mode. SCL timing comes only from the internal divider.

Top module: `i2c_lite_master`

## Requirements
- R1: A start command (cmd_op_i = 2'b00) makes SDA fall while SCL is high. SCL then stays high for exactly div_i system clocks. The command completes with SCL low and SDA pulled low.
- R2: A stop command (cmd_op_i = 2'b01) makes SDA rise while SCL is high. The command completes with SCL high and SDA released.
- R3: A write command (cmd_op_i = 2'b10) sends tx_byte_i MSB first. Each bit is valid at the rising edge of SCL. SDA changes only while SCL is low, so no start or stop condition appears during a byte. SDA is released for the 9th (acknowledge) clock.
- R4: During a byte, each SCL high half lasts div_i + 1 system clocks, which gives an SCL period of 2 × (div_i + 1) clocks.
- R5: A high SDA level at the acknowledge clock of a write sets nack_err_o, which is visible the cycle after done_o. The flag stays set across later acknowledged writes. A one-cycle pulse on nack_clr_i clears it. An acknowledged write leaves a clear flag clear.
- R6: A read command (cmd_op_i = 2'b11) shifts in the SDA level during each of 8 SCL high halves, MSB first. The byte appears on rx_byte_o in the same cycle as done_o.
- R7: On the 9th clock of a read, SDA is driven low if rx_ack_en_i was 1 when the command was accepted. Otherwise SDA stays released (NACK).
- R8: busy_o rises the cycle after a command is accepted and falls in the cycle where done_o pulses. done_o lasts exactly one cycle.
- R9: A command presented while busy_o is high is ignored: the running byte and the bus are unaffected. It sets overrun_o, which a pulse on ovr_clr_i clears.
- R10: After reset, SCL is high, SDA is released, and busy_o, done_o, nack_err_o and overrun_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Half-period divider: each SCL half lasts div_i + 1 clocks |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 2 | 00 start, 01 stop, 10 write byte, 11 read byte |
| tx_byte_i | input | 8 | Byte to send on a write command |
| rx_ack_en_i | input | 1 | 1: acknowledge a read byte; 0: leave SDA released |
| nack_clr_i | input | 1 | Clears nack_err_o |
| ovr_clr_i | input | 1 | Clears overrun_o |
| sda_i | input | 1 | Resolved SDA bus level |
| scl_o | output | 1 | SCL level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse for every command |
| nack_err_o | output | 1 | Sticky missing-acknowledge flag |
| overrun_o | output | 1 | Sticky flag for a command issued while busy |
| rx_byte_o | output | 8 | Last byte received |

## Verification
The embedded properties assume that div_i is at least 1 and is not changed while a command is running. Under that assumption the divider count stays in bounds and SDA always settles one clock after SCL falls. The bench writes div_i (values 1, 2, 3 and 5) only between commands, while busy_o is low. Its slave model changes SDA only a short delay after a falling SCL edge, so the sampled levels are never racing against SCL.

// File: rtl/i2c_lite_pkg.sv
package i2c_lite_pkg;

    localparam int BYTE_W = 8;
    localparam int PH_W   = 5;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_STOP  = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } op_e;

    // Bus levels for one phase; sda = 1 means released
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    // Index of the final phase of each command (each phase is one SCL half)
    function automatic logic [PH_W-1:0] last_phase(op_e op);
        case (op)
            OP_START: return 5'd3;
            OP_STOP:  return 5'd2;
            default:  return 5'd18;
        endcase
    endfunction

    // Bus levels wanted in a given phase of a command
    function automatic lines_t phase_lines(op_e op, logic [PH_W-1:0] ph,
                                           logic [BYTE_W-1:0] data, logic ack_low);
        lines_t l;
        l.scl = 1'b1;
        l.sda = 1'b1;
        case (op)
            OP_START: begin
                l.scl = (ph == 5'd1) || (ph == 5'd2);
                l.sda = (ph == 5'd0) || (ph == 5'd1);
            end
            OP_STOP: begin
                l.scl = (ph != 5'd0);
                l.sda = (ph == 5'd2);
            end
            default: begin
                l.scl = ph[0];
                if (ph >= 5'd16)
                    l.sda = (op == OP_READ && ph != 5'd18) ? !ack_low : 1'b1;
                else
                    l.sda = (op == OP_WRITE) ? data[3'd7 - ph[3:1]] : 1'b1;
            end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/i2c_lite_tick.sv
module i2c_lite_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (run)
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end

    // R4: the half-period count never passes the divider while running
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= div));

endmodule

// File: rtl/i2c_lite_seq.sv
module i2c_lite_seq
    import i2c_lite_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  op_e               op,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ack_low,
    input  logic              tick,
    input  logic              sda_in,
    output logic              busy,
    output logic              done,
    output logic              scl,
    output logic              sda,
    output logic              nack_evt,
    output logic [BYTE_W-1:0] rdata
);
    op_e               op_q;
    logic [PH_W-1:0]   ph_q;
    logic [BYTE_W-1:0] dat_q;
    logic              ack_low_q;
    logic              sda_pend;
    logic              ack_seen_q;
    lines_t            first_l, cur_l, next_l;
    logic              final_tick, high_end;

    always_comb begin
        first_l    = phase_lines(op, '0, wdata, ack_low);
        cur_l      = phase_lines(op_q, ph_q, dat_q, ack_low_q);
        next_l     = phase_lines(op_q, ph_q + 5'd1, dat_q, ack_low_q);
        final_tick = tick && (ph_q == last_phase(op_q));
        high_end   = tick && ph_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            op_q       <= OP_START;
            ph_q       <= '0;
            dat_q      <= '0;
            ack_low_q  <= 1'b0;
            sda_pend   <= 1'b0;
            ack_seen_q <= 1'b0;
            scl        <= 1'b1;
            sda        <= 1'b1;
            nack_evt   <= 1'b0;
            rdata      <= '0;
        end else begin
            done     <= 1'b0;
            nack_evt <= 1'b0;
            // SDA follows its phase one clock after SCL moves
            if (sda_pend) begin
                sda      <= cur_l.sda;
                sda_pend <= 1'b0;
            end
            if (accept) begin
                busy      <= 1'b1;
                op_q      <= op;
                ph_q      <= '0;
                dat_q     <= wdata;
                ack_low_q <= ack_low;
                scl       <= first_l.scl;
                sda_pend  <= 1'b1;
            end else if (tick) begin
                if (high_end) begin
                    if (op_q == OP_READ && ph_q < 5'd16)
                        dat_q <= {dat_q[BYTE_W-2:0], sda_in};
                    if (ph_q == 5'd17)
                        ack_seen_q <= sda_in;
                end
                if (final_tick) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    nack_evt <= (op_q == OP_WRITE) && ack_seen_q;
                    if (op_q == OP_READ)
                        rdata <= dat_q;
                end else begin
                    ph_q     <= ph_q + 5'd1;
                    scl      <= next_l.scl;
                    sda_pend <= 1'b1;
                end
            end
        end
    end

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: busy has dropped when completion is signalled
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R8: an accepted command makes the block busy
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    // R3: inside a byte, SDA holds while SCL stays high
    p_byte_sda_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && op_q[1] && scl && $past(scl)) |-> $stable(sda));

endmodule

// File: rtl/i2c_lite_master.sv
module i2c_lite_master
    import i2c_lite_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [7:0]       tx_byte_i,
    input  logic             rx_ack_en_i,
    input  logic             nack_clr_i,
    input  logic             ovr_clr_i,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             nack_err_o,
    output logic             overrun_o,
    output logic [7:0]       rx_byte_o
);
    logic accept, tick, sda_lvl, nack_evt;
    logic nack_q, ovr_q;

    assign accept = cmd_valid_i && !busy_o;

    i2c_lite_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (busy_o),
        .div     (div_i),
        .tick    (tick)
    );

    i2c_lite_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .op       (op_e'(cmd_op_i)),
        .wdata    (tx_byte_i),
        .ack_low  (rx_ack_en_i),
        .tick     (tick),
        .sda_in   (sda_i),
        .busy     (busy_o),
        .done     (done_o),
        .scl      (scl_o),
        .sda      (sda_lvl),
        .nack_evt (nack_evt),
        .rdata    (rx_byte_o)
    );

    assign sda_oe_o = !sda_lvl;

    // Sticky flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            nack_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            nack_q <= nack_evt || (nack_q && !nack_clr_i);
            ovr_q  <= (cmd_valid_i && busy_o) || (ovr_q && !ovr_clr_i);
        end
    end

    assign nack_err_o = nack_q;
    assign overrun_o  = ovr_q;

    // R9: a command while busy is always recorded
    p_ovr_set_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && busy_o) |=> overrun_o);
    // R5: the error flag only rises right after a completion
    p_nack_src_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(nack_err_o) |-> $past(done_o));

endmodule

// File: tb/i2c_lite_master_tb.sv
`timescale 1ns/1ps
module i2c_lite_master_tb;
    import i2c_lite_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_r = 8'd3;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_ack_en = 1'b0;
    logic       nack_clr = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       slave_pull = 1'b0;
    logic       sda_bus;
    logic       scl_o, sda_oe_o, busy_o, done_o, nack_err_o, overrun_o;
    logic [7:0] rx_byte_o;

    int nchk = 0, nfail = 0, start_cnt = 0, stop_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = !(sda_oe_o || slave_pull);

    i2c_lite_master #(.DIV_W(8)) u_dut (
        .clk(clk), .rst(rst), .div_i(div_r), .cmd_valid_i(cmd_valid),
        .cmd_op_i(cmd_op), .tx_byte_i(tx_byte), .rx_ack_en_i(rx_ack_en),
        .nack_clr_i(nack_clr), .ovr_clr_i(ovr_clr), .sda_i(sda_bus),
        .scl_o(scl_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o),
        .nack_err_o(nack_err_o), .overrun_o(overrun_o), .rx_byte_o(rx_byte_o)
    );

    always @(negedge sda_bus) if (scl_o === 1'b1) start_cnt++;
    always @(posedge sda_bus) if (scl_o === 1'b1) stop_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    task automatic issue(input op_e op, input logic [7:0] d, input logic ae, input bit expect_accept);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; tx_byte = d; rx_ack_en = ae;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (expect_accept) chk("R8 busy after accept", busy_o, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_o !== 1'b1 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 done seen", done_o, 1);
        chk("R8 busy low at done", busy_o, 0);
        @(negedge clk);
        chk("R8 done one cycle", done_o, 0);
    endtask

    task automatic t_reset();
        chk("R10 scl high", scl_o, 1);
        chk("R10 sda released", sda_oe_o, 0);
        chk("R10 busy low", busy_o, 0);
        chk("R10 done low", done_o, 0);
        chk("R10 nack clear", nack_err_o, 0);
        chk("R10 overrun clear", overrun_o, 0);
    endtask

    task automatic t_start();
        int s0 = start_cnt;
        time t1, t2;
        issue(OP_START, 8'h00, 1'b0, 1'b1);
        @(negedge sda_bus); t1 = $time;
        chk("R1 scl high at sda fall", scl_o, 1);
        @(negedge scl_o); t2 = $time;
        chk("R1 start hold clocks", int'((t2 - t1) / 4), {24'd0, div_r});
        wait_done();
        chk("R1 one start seen", start_cnt, s0 + 1);
        chk("R1 scl low at end", scl_o, 0);
        chk("R1 sda low at end", sda_bus, 0);
    endtask

    task automatic t_stop();
        int p0 = stop_cnt;
        issue(OP_STOP, 8'h00, 1'b0, 1'b1);
        @(posedge sda_bus);
        chk("R2 scl high at sda rise", scl_o, 1);
        wait_done();
        chk("R2 one stop seen", stop_cnt, p0 + 1);
        chk("R2 scl high at end", scl_o, 1);
        chk("R2 sda released at end", sda_bus, 1);
    endtask

    task automatic t_write(input logic [7:0] d, input bit give_nack, input bit poke);
        int s0 = start_cnt, p0 = stop_cnt;
        logic e0 = nack_err_o;
        logic [7:0] got = 8'h00;
        time tr = 0, tf = 0;
        issue(OP_WRITE, d, 1'b0, 1'b1);
        fork
            begin
                for (int i = 7; i >= 0; i--) begin
                    @(posedge scl_o); tr = $time;
                    #1 got[i] = sda_bus;
                end
                @(negedge scl_o); tf = $time;
                #1 slave_pull = !give_nack;
                @(posedge scl_o);
                @(negedge scl_o);
                #1 slave_pull = 1'b0;
            end
            begin
                if (poke) begin
                    repeat (6) @(negedge clk);
                    issue(OP_STOP, 8'hFF, 1'b0, 1'b0);
                end
            end
        join
        wait_done();
        chk("R3 write bits MSB first", got, d);
        chk("R4 scl high clocks", int'((tf - tr) / 4), div_r + 1);
        chk("R3 no start inside byte", start_cnt, s0);
        chk("R3 no stop inside byte", stop_cnt, p0);
        if (give_nack)
            chk("R5 nack sets error", nack_err_o, 1);
        else if (e0)
            chk("R5 error stays sticky", nack_err_o, 1);
        else
            chk("R5 ack leaves error clear", nack_err_o, 0);
        if (poke) chk("R9 overrun set", overrun_o, 1);
    endtask

    task automatic t_read(input logic [7:0] d, input logic ae);
        logic ackv;
        slave_pull = !d[7];
        issue(OP_READ, 8'h00, ae, 1'b1);
        for (int i = 6; i >= 0; i--) begin
            @(negedge scl_o);
            #1 slave_pull = !d[i];
        end
        @(negedge scl_o);
        #1 slave_pull = 1'b0;
        @(posedge scl_o);
        #1 ackv = sda_bus;
        chk(ae ? "R7 ack driven low" : "R7 nack left released", ackv, ae ? 0 : 1);
        wait_done();
        chk("R6 read byte", rx_byte_o, d);
    endtask

    task automatic t_nack_clear();
        @(negedge clk); nack_clr = 1'b1;
        @(negedge clk); nack_clr = 1'b0;
        chk("R5 clear by pulse", nack_err_o, 0);
    endtask

    task automatic t_ovr_clear();
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R9 overrun cleared", overrun_o, 0);
    endtask

    initial begin
        #(4 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();

        div_r = 8'd3;
        t_start();
        t_write(8'hA6, 1'b0, 1'b0);
        t_read(8'h5C, 1'b1);
        t_read(8'h3B, 1'b0);
        t_stop();

        div_r = 8'd1;
        t_start();
        t_write(8'h55, 1'b1, 1'b0);
        t_write(8'h0F, 1'b0, 1'b0);
        t_nack_clear();
        t_stop();

        div_r = 8'd2;
        t_start();
        t_write(8'hC3, 1'b0, 1'b1);
        t_ovr_clear();
        t_stop();

        div_r = 8'd5;
        t_start();
        t_write(8'h81, 1'b0, 1'b0);
        t_read(8'hE4, 1'b0);
        t_stop();

        finish_run();
    end

endmodule